// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

This block adds two unsigned binary operands and a carry-in and produces a sum and a carry-out, with no clock and no storage. Each bit first forms a generate term (both operand bits set) and a propagate term. The operand bits are cut into slices of four. Inside a slice, every carry is computed at once from the slice's carry-in, using the fully expanded lookahead equations, so no carry waits on the carry below it.

Slices are chained: the carry-out of one slice is the carry-in of the next, so the carry ripples only across slice boundaries. A wider adder costs one slice delay per four bits rather than one delay per bit. The sum of each bit is the exclusive-OR of the two operand bits, exclusive-ORed again with the carry into that bit. The inclusive-OR propagate may only appear in the carry equations. A parameter chooses which propagate form the carry logic uses; both give the same results.

The block is purely combinational and has no valid/ready handshake. Outputs follow the inputs after the logic settles, and callers register them as they need.

Top module: `cla_adder`

## Requirements
- R1: `sum_out` equals `(a_in + b_in + carry_in) mod 2^WIDTH` for every input combination.
- R2: `carry_out` equals bit WIDTH of the full-precision value `a_in + b_in + carry_in`.
- R3: With `a_in` all ones and `b_in` zero, `carry_in`=0 gives `sum_out` all ones and `carry_out`=0, and `carry_in`=1 gives `sum_out`=0 and `carry_out`=1.
- R4: With both operands all ones, `carry_in`=0 gives `sum_out` equal to all ones except bit 0 cleared and `carry_out`=1, and `carry_in`=1 gives `sum_out` all ones and `carry_out`=1.
- R5: The carry into 4-bit slice k (bits 4k..4k+3) is 1 exactly when the low 4k bits of `a_in + b_in + carry_in` overflow. This is seen at the ports through the sum bits of slice k, and is checked for operands whose carry crosses every slice boundary.
- R6: When `a_in & b_in` is zero and `carry_in` is 0, `sum_out` equals `a_in | b_in` and `carry_out` is 0. No carry is generated from propagate terms alone.
- R7: Setting the parameter CARRY_USES_XOR to 0 (OR-form propagate in the carry) or to 1 (XOR-form propagate) does not change `sum_out` or `carry_out` for any input.
- R8: All-zero operands with `carry_in`=0 give `sum_out`=0 and `carry_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top slice |

## Verification
The bench builds two copies side by side. One is 16 bits wide, four slices, with OR-form propagate in the carry logic. The other is 8 bits wide, two slices, with XOR-form propagate. The 16-bit copy exercises carries that cross three slice boundaries. Driving both copies with the same low bits compares the two propagate choices on identical operands, which is what R7 claims.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned SLICE_BITS = 4;

  typedef struct packed {
    logic gen;
    logic prop_or;
    logic prop_xor;
  } bit_terms_t;
endpackage

// File: rtl/cla_bit_terms.sv
module cla_bit_terms
  import cla_pkg::*;
(
  input  logic       op_x,
  input  logic       op_y,
  output bit_terms_t terms
);
  always_comb begin
    terms.gen      = op_x & op_y;
    terms.prop_or  = op_x | op_y;
    terms.prop_xor = op_x ^ op_y;
  end
endmodule

// File: rtl/cla_lookahead4.sv
module cla_lookahead4 (
  input  logic [3:0] gen,
  input  logic [3:0] prop,
  input  logic       c_base,
  output logic [4:1] c_out
);
  // Every carry is formed straight from c_base; none waits on a lower carry.
  always_comb begin
    c_out[1] = gen[0] | (prop[0] & c_base);
    c_out[2] = gen[1] | (prop[1] & gen[0]) | (prop[1] & prop[0] & c_base);
    c_out[3] = gen[2] | (prop[2] & gen[1]) | (prop[2] & prop[1] & gen[0])
             | (prop[2] & prop[1] & prop[0] & c_base);
    c_out[4] = gen[3] | (prop[3] & gen[2]) | (prop[3] & prop[2] & gen[1])
             | (prop[3] & prop[2] & prop[1] & gen[0])
             | (prop[3] & prop[2] & prop[1] & prop[0] & c_base);
  end
endmodule

// File: rtl/cla_slice4.sv
module cla_slice4
  import cla_pkg::*;
#(
  parameter bit CARRY_USES_XOR = 1'b0
) (
  input  logic [SLICE_BITS-1:0] x,
  input  logic [SLICE_BITS-1:0] y,
  input  logic                  c_enter,
  output logic [SLICE_BITS-1:0] s,
  output logic                  c_leave
);
  bit_terms_t [SLICE_BITS-1:0] terms;
  logic [SLICE_BITS-1:0] gen_v, prop_carry, prop_sum;
  logic [SLICE_BITS:1]   c_int;
  logic [SLICE_BITS-1:0] c_into;

  for (genvar i = 0; i < SLICE_BITS; i++) begin : g_bit
    cla_bit_terms u_terms (.op_x(x[i]), .op_y(y[i]), .terms(terms[i]));
    assign gen_v[i]    = terms[i].gen;
    assign prop_sum[i] = terms[i].prop_xor;
    if (CARRY_USES_XOR) begin : g_px
      assign prop_carry[i] = terms[i].prop_xor;
    end else begin : g_po
      assign prop_carry[i] = terms[i].prop_or;
    end
  end

  cla_lookahead4 u_la (
    .gen(gen_v), .prop(prop_carry), .c_base(c_enter), .c_out(c_int)
  );

  assign c_into  = {c_int[SLICE_BITS-1:1], c_enter};
  // The sum must use the XOR-form propagate whatever the carry logic uses.
  assign s       = prop_sum ^ c_into;
  assign c_leave = c_int[SLICE_BITS];
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH          = 16,
  parameter bit          CARRY_USES_XOR = 1'b0
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int unsigned NSLICE = WIDTH / SLICE_BITS;

  logic [NSLICE:0] slice_c;
  assign slice_c[0] = carry_in;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    cla_slice4 #(.CARRY_USES_XOR(CARRY_USES_XOR)) u_slice (
      .x      (a_in[k*SLICE_BITS +: SLICE_BITS]),
      .y      (b_in[k*SLICE_BITS +: SLICE_BITS]),
      .c_enter(slice_c[k]),
      .s      (sum_out[k*SLICE_BITS +: SLICE_BITS]),
      .c_leave(slice_c[k+1])
    );
  end

  assign carry_out = slice_c[NSLICE];
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0]   a_in,
  input logic [WIDTH-1:0]   b_in,
  input logic               carry_in,
  input logic [WIDTH-1:0]   sum_out,
  input logic               carry_out,
  input logic [WIDTH/4:0]   slice_c
);
  localparam int unsigned NS = WIDTH / 4;
  logic [WIDTH:0] total;

  always_comb begin
    total = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in};
    p_sum_r1: assert (sum_out == total[WIDTH-1:0]);
    p_cout_r2: assert (carry_out == total[WIDTH]);
    if (((a_in & b_in) == '0) && !carry_in) begin
      p_no_gen_r6: assert (sum_out == (a_in | b_in) && !carry_out);
    end
    if (a_in == '1 && b_in == '0) begin
      p_ones_r3: assert (carry_out == carry_in && sum_out == {WIDTH{!carry_in}});
    end
  end

  for (genvar k = 1; k < NS; k++) begin : g_sc
    logic [WIDTH:0] low_mask, low_sum;
    always_comb begin
      low_mask = ({{WIDTH{1'b0}}, 1'b1} << (4*k)) - 1'b1;
      low_sum  = ({1'b0, a_in} & low_mask) + ({1'b0, b_in} & low_mask)
               + {{WIDTH{1'b0}}, carry_in};
      p_slice_carry_r5: assert (slice_c[k] == low_sum[4*k]);
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in(a_in), .b_in(b_in), .carry_in(carry_in),
  .sum_out(sum_out), .carry_out(carry_out), .slice_c(slice_c)
);

// File: tb/sim_cla_adder.sv
`timescale 1ns/1ps
module sim_cla_adder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        ci  = 1'b0, co16, co8;
  logic [7:0]  s8;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cla_adder #(.WIDTH(16), .CARRY_USES_XOR(1'b0)) u0 (
    .a_in(a16), .b_in(b16), .carry_in(ci), .sum_out(s16), .carry_out(co16));
  cla_adder #(.WIDTH(8), .CARRY_USES_XOR(1'b1)) u1 (
    .a_in(a16[7:0]), .b_in(b16[7:0]), .carry_in(ci), .sum_out(s8), .carry_out(co8));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: plain integer arithmetic, compared each clock.
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c,
                       input string tag);
    int unsigned full16, full8;
    @(posedge clk);
    a16 = a; b16 = b; ci = c;
    @(negedge clk);
    full16 = 32'(a) + 32'(b) + 32'(c);
    full8  = 32'(a[7:0]) + 32'(b[7:0]) + 32'(c);
    check({tag, " R1 sum16"},  32'(s16), full16 & 32'hFFFF);
    check({tag, " R2 cout16"}, 32'(co16), (full16 >> 16) & 1);
    check({tag, " R7 sum8"},   32'(s8),  full8 & 32'hFF);
    check({tag, " R7 cout8"},  32'(co8), (full8 >> 8) & 1);
    check({tag, " R7 low byte agrees"}, 32'(s8), 32'(s16[7:0]));
  endtask

  initial begin
    #1;
    check("R8 idle sum", 32'(s16), 0);
    check("R8 idle cout", 32'(co16), 0);
    apply(16'h0000, 16'h0000, 1'b0, "R8");
    apply(16'hFFFF, 16'h0000, 1'b0, "R3");
    check("R3 ones cin0 sum", 32'(s16), 32'hFFFF);
    check("R3 ones cin0 cout", 32'(co16), 0);
    apply(16'hFFFF, 16'h0000, 1'b1, "R3");
    check("R3 ones cin1 sum", 32'(s16), 0);
    check("R3 ones cin1 cout", 32'(co16), 1);
    apply(16'hFFFF, 16'hFFFF, 1'b0, "R4");
    check("R4 both ones cin0 sum", 32'(s16), 32'hFFFE);
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R4");
    check("R4 both ones cin1 sum", 32'(s16), 32'hFFFF);
    check("R4 both ones cin1 cout", 32'(co16), 1);
    // R5: carries crossing each slice boundary
    apply(16'h000F, 16'h0001, 1'b0, "R5");
    check("R5 slice1 entry", 32'(s16), 32'h0010);
    apply(16'h00FF, 16'h0000, 1'b1, "R5");
    check("R5 slice2 entry", 32'(s16), 32'h0100);
    apply(16'h0FF0, 16'h0010, 1'b0, "R5");
    check("R5 slice3 entry", 32'(s16), 32'h1000);
    apply(16'h8000, 16'h8000, 1'b0, "R5");
    check("R5 top carry", 32'(co16), 1);
    // R6: disjoint operands, no carry anywhere
    apply(16'hA5A5, 16'h5A5A, 1'b0, "R6");
    check("R6 disjoint sum", 32'(s16), 32'hFFFF);
    check("R6 disjoint cout", 32'(co16), 0);
    apply(16'h1234, 16'h4008, 1'b0, "R6");
    check("R6 disjoint sum2", 32'(s16), 32'h523C);
    for (int n = 0; n < 400; n++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule